// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a data cache that sits after address translation and is looked up with a 32-bit physical address. Each line is one 32-bit word. The cache is direct mapped: the index field picks one line, and a stored tag plus a valid bit decide whether the access is a hit. The CPU raises a request only together with a translation-ok strobe. When translation misses or the access is not permitted, the request is dropped before it reaches the cache.

A read that hits returns the word in the same cycle. A read that misses holds the CPU stalled while the block fetches the word from memory and installs it in the line. Writes do not look up the cache. A full-word write replaces the line's data and tag. A write with only some bytes enabled invalidates the line. In both cases the address, data and byte enables go into a small first-in first-out write buffer, which drains to memory through its own handshake port while the CPU continues. A read miss never fetches from memory while the buffer still holds a write to the same word.

After reset the block clears every valid bit, one line per cycle, and signals busy until the sweep ends.

Top module: `wt_dcache`

## Requirements
- R1: After reset release, `busy` stays high for exactly 2^IDX_W cycles while the lines are cleared one per cycle. Any request made while busy sees `cpu_stall` high. When busy falls, every line is invalid, so the first read of any address misses.
- R2: A read whose line is valid and whose stored tag matches returns the stored word on `cpu_rdata` in the same cycle, with `cpu_stall` low and no memory read.
- R3: On a read miss, `cpu_stall` stays high and `mem_rd_req` is raised with `mem_rd_addr` equal to the request address with bits [1:0] cleared. Both are held unchanged until `mem_rd_valid`. The next cycle the held read hits and returns `mem_rd_data`.
- R4: A write with `cpu_be` = 4'b1111, made when the buffer has room, completes with no stall. It sets that line's data and tag unconditionally and evicts whatever address was there. A later read of the written address hits with the new data.
- R5: Every accepted write enters the write buffer. The buffer presents its entries on `wb_addr`/`wb_data`/`wb_be` in acceptance order. The head entry leaves in each cycle where `wb_valid` and `wb_ready` are both high, and it stays stable otherwise.
- R6: The write buffer holds WB_DEPTH entries (4 by default). A write arriving when it is full is stalled and not queued until an entry drains.
- R7: A write whose `cpu_be` is not 4'b1111 invalidates its line instead of updating it, and it is still queued with its byte enables. A later read of that address misses.
- R8: While a read miss is pending and the buffer holds any write to the same word address (address bits [31:2]), `mem_rd_req` stays low. It rises only after all such writes have drained.
- R9: A request with `xlat_ok` low has no effect: no stall, no change to any line, no buffer entry and no memory read.
- R10: Address bits [1:0] are the byte offset, bits [IDX_W+1:2] the line index and the remaining upper bits the tag. Two addresses that share an index but differ in tag evict each other, and the byte offset does not affect hit or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_addr | input | 32 | Physical byte address from translation |
| cpu_wdata | input | 32 | Write data |
| xlat_ok | input | 1 | Translation hit and access permitted |
| cpu_rdata | output | 32 | Read data, valid when a read is not stalled |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| busy | output | 1 | Post-reset valid-bit sweep in progress |
| mem_rd_req | output | 1 | Memory read request for a line fill |
| mem_rd_addr | output | 32 | Word-aligned fill address |
| mem_rd_valid | input | 1 | Fill data returned |
| mem_rd_data | input | 32 | Fill data word |
| wb_valid | output | 1 | Write buffer head is valid |
| wb_addr | output | 32 | Head entry address |
| wb_data | output | 32 | Head entry data |
| wb_be | output | 4 | Head entry byte enables |
| wb_ready | input | 1 | Memory accepts the head entry |

## Verification
The bench builds the cache with IDX_W = 3 and WB_DEPTH = 4. With eight lines, a sweep can visit every index under two different tags, so each line goes through a cold miss, a hit and a conflict eviction. The sweep length after reset is short enough to count exactly. A buffer of four entries can be filled and then overrun on purpose. The bench holds `wb_ready` low to freeze the drain, which lets it observe the full-buffer stall, the in-order drain and a miss held back by matching buffered writes. Expected read data comes from an arithmetic function of the address that the bench's memory model also uses to answer fills.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ST_SWEEP = 2'd0,
    ST_RUN   = 2'd1,
    ST_MISS  = 2'd2
  } wtc_state_e;

  function automatic logic [31:0] word_base(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic is_full_word(input logic [3:0] be);
    return be == 4'hF;
  endfunction

endpackage

// File: rtl/wtc_store.sv
module wtc_store #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             sweep_en,
  input  logic [IDX_W-1:0] sweep_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [31:0]      rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [31:0]      wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic             vld_q [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [31:0]      dat_q [LINES];

  always_ff @(posedge clk) begin
    if (sweep_en) begin
      vld_q[sweep_idx] <= 1'b0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= wr_valid;
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [31:0] push_addr,
  input  logic [31:0] push_data,
  input  logic [3:0]  push_be,
  output logic        full,
  output logic        head_valid,
  output logic [31:0] head_addr,
  output logic [31:0] head_data,
  output logic [3:0]  head_be,
  input  logic        head_ready,
  input  logic [29:0] probe_word,
  output logic        probe_hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]      a_q  [DEPTH];
  logic [31:0]      d_q  [DEPTH];
  logic [3:0]       be_q [DEPTH];
  logic [DEPTH-1:0] occ_q;
  logic [DEPTH-1:0] slot_hit;
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic             do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = &occ_q;
  assign head_valid = |occ_q;
  assign do_pop     = head_valid && head_ready;
  assign head_addr  = a_q[rd_ptr];
  assign head_data  = d_q[rd_ptr];
  assign head_be    = be_q[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (do_pop) begin
        occ_q[rd_ptr] <= 1'b0;
        rd_ptr        <= bump(rd_ptr);
      end
      if (push) begin
        occ_q[wr_ptr] <= 1'b1;
        wr_ptr        <= bump(wr_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      a_q[wr_ptr]  <= push_addr;
      d_q[wr_ptr]  <= push_data;
      be_q[wr_ptr] <= push_be;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign slot_hit[i] = occ_q[i] && (a_q[i][31:2] == probe_word);
  end

  assign probe_hit = |slot_hit;
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wtc_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int WB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [3:0]  cpu_be,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic        xlat_ok,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic        busy,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        wb_valid,
  output logic [31:0] wb_addr,
  output logic [31:0] wb_data,
  output logic [3:0]  wb_be,
  input  logic        wb_ready
);
  localparam int OFF_W = 2;
  localparam int TAG_W = 32 - IDX_W - OFF_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [31:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [31:0] a);
    return a[31 -: TAG_W];
  endfunction

  wtc_state_e       state_q;
  logic [IDX_W-1:0] sweep_q;
  logic [31:0]      miss_addr_q;

  // named internal events
  logic             access, in_run, tag_hit;
  logic             rd_hit, rd_miss, wr_accept, fill_done;
  logic             wb_full, wb_match;
  logic             line_valid;
  logic [TAG_W-1:0] line_tag;
  logic [31:0]      line_data;
  logic             st_wr_en, st_wr_valid;
  logic [IDX_W-1:0] st_wr_idx;
  logic [TAG_W-1:0] st_wr_tag;
  logic [31:0]      st_wr_data;

  assign access    = cpu_req && xlat_ok;
  assign in_run    = (state_q == ST_RUN);
  assign busy      = (state_q == ST_SWEEP);
  assign tag_hit   = line_valid && (line_tag == tag_of(cpu_addr));
  assign rd_hit    = in_run && access && !cpu_we && tag_hit;
  assign rd_miss   = in_run && access && !cpu_we && !tag_hit;
  assign wr_accept = in_run && access && cpu_we && !wb_full;

  assign mem_rd_req  = (state_q == ST_MISS) && !wb_match;
  assign mem_rd_addr = miss_addr_q;
  assign fill_done   = mem_rd_req && mem_rd_valid;

  assign cpu_stall = (cpu_req && busy) || (access && !(rd_hit || wr_accept));
  assign cpu_rdata = line_data;

  assign st_wr_en    = wr_accept || fill_done;
  assign st_wr_idx   = fill_done ? idx_of(miss_addr_q) : idx_of(cpu_addr);
  assign st_wr_tag   = fill_done ? tag_of(miss_addr_q) : tag_of(cpu_addr);
  assign st_wr_data  = fill_done ? mem_rd_data : cpu_wdata;
  assign st_wr_valid = fill_done || is_full_word(cpu_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_SWEEP;
      sweep_q     <= '0;
      miss_addr_q <= '0;
    end else begin
      unique case (state_q)
        ST_SWEEP: begin
          sweep_q <= sweep_q + 1'b1;
          if (&sweep_q) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (rd_miss) begin
            miss_addr_q <= word_base(cpu_addr);
            state_q     <= ST_MISS;
          end
        end
        ST_MISS: begin
          if (fill_done) state_q <= ST_RUN;
        end
        default: state_q <= ST_SWEEP;
      endcase
    end
  end

  wtc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .sweep_en  (busy),
    .sweep_idx (sweep_q),
    .rd_idx    (idx_of(cpu_addr)),
    .rd_valid  (line_valid),
    .rd_tag    (line_tag),
    .rd_data   (line_data),
    .wr_en     (st_wr_en),
    .wr_idx    (st_wr_idx),
    .wr_valid  (st_wr_valid),
    .wr_tag    (st_wr_tag),
    .wr_data   (st_wr_data)
  );

  wtc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wr_accept),
    .push_addr  (cpu_addr),
    .push_data  (cpu_wdata),
    .push_be    (cpu_be),
    .full       (wb_full),
    .head_valid (wb_valid),
    .head_addr  (wb_addr),
    .head_data  (wb_data),
    .head_be    (wb_be),
    .head_ready (wb_ready),
    .probe_word (miss_addr_q[31:2]),
    .probe_hit  (wb_match)
  );
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        xlat_ok,
  input logic        busy,
  input logic        cpu_stall,
  input logic        mem_rd_req,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_addr,
  input logic        wb_valid,
  input logic        wb_ready,
  input logic [31:0] wb_addr,
  input logic        wb_full,
  input logic        wb_match
);
  // R1
  sweep_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && busy |-> cpu_stall);

  // R3
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

  // R3
  fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> mem_rd_addr[1:0] == 2'b00);

  // R5
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && xlat_ok && cpu_we && wb_full && !busy |-> cpu_stall);

  // R8
  drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !wb_match);

  // R9
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !xlat_ok && !busy |-> !cpu_stall);
endmodule

bind wt_dcache wtc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .xlat_ok      (xlat_ok),
  .busy         (busy),
  .cpu_stall    (cpu_stall),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_addr  (mem_rd_addr),
  .wb_valid     (wb_valid),
  .wb_ready     (wb_ready),
  .wb_addr      (wb_addr),
  .wb_full      (wb_full),
  .wb_match     (wb_match)
);

// File: tb/test_wt_dcache.sv
module test_wt_dcache;
  localparam int IDX_W    = 3;
  localparam int WB_DEPTH = 4;
  localparam int LINES    = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, xlat_ok = 1'b1;
  logic [3:0]  cpu_be = 4'hF;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall, busy;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        wb_valid;
  logic [31:0] wb_addr, wb_data;
  logic [3:0]  wb_be;
  logic        wb_ready = 1'b0;

  always #10 clk = ~clk;

  wt_dcache #(.IDX_W(IDX_W), .WB_DEPTH(WB_DEPTH)) i_wt_dcache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_be(cpu_be), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .xlat_ok(xlat_ok), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .busy(busy), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_be(wb_be), .wb_ready(wb_ready)
  );

  int checks = 0, errors = 0, fills = 0, lat = 0;
  int n_push = 0, n_pop = 0;
  logic        done = 1'b0;
  logic [31:0] exp_a [64];
  logic [31:0] exp_d [64];
  logic [3:0]  exp_be [64];

  function automatic logic [31:0] mval(input logic [31:0] a);
    return a * 32'h9E37_79B9 + 32'h1234_5678;
  endfunction

  function automatic logic [31:0] mk(input int t, input int i);
    return (32'(t) << (IDX_W + 2)) | (32'(i) << 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers a fill two cycles after the request is seen
  initial forever begin
    @(negedge clk);
    if (mem_rd_req && !mem_rd_valid) begin
      lat++;
      if (lat >= 2) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mval(mem_rd_addr);
        lat = 0;
      end
    end else begin
      mem_rd_valid = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (mem_rd_req && mem_rd_valid) fills++;
    if (rst_n && wb_valid && wb_ready) begin
      chk("R5 drain addr", wb_addr, exp_a[n_pop]);
      chk("R5 drain data", wb_data, exp_d[n_pop]);
      chk("R5 drain be", 32'(wb_be), 32'(exp_be[n_pop]));
      n_pop++;
    end
  end

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; xlat_ok = 1'b1;
    #1; waits = 0;
    while (cpu_stall && waits < 200) begin @(negedge clk); #1; waits++; end
    d = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                    output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_be = be; xlat_ok = 1'b1;
    #1; waits = 0;
    while (cpu_stall && waits < 200) begin @(negedge clk); #1; waits++; end
    exp_a[n_push] = a; exp_d[n_push] = d; exp_be[n_push] = be; n_push++;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int w, f0, cnt, seen_pop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cpu_req = 1'b1; cpu_addr = mk(5, 0);
    #1;
    chk("R1 busy after reset", 32'(busy), 1);
    chk("R1 stall while busy", 32'(cpu_stall), 1);
    cpu_req = 1'b0;
    cnt = 0;
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); #1; end
    chk("R1 sweep length", 32'(cnt), 32'(LINES));

    // R1 R3 R2: cold miss then hit on every line
    for (int i = 0; i < LINES; i++) begin
      f0 = fills;
      rd(mk(5, i), d, w);
      chk("R1 R3 cold miss stalls", 32'(w > 0), 1);
      chk("R3 fill data", d, mval(mk(5, i)));
      chk("R3 one fill", 32'(fills - f0), 1);
      rd(mk(5, i), d, w);
      chk("R2 hit no stall", 32'(w), 0);
      chk("R2 hit data", d, mval(mk(5, i)));
      chk("R2 no fill on hit", 32'(fills - f0), 1);
    end

    // R10: byte offset ignored, conflicting tags evict
    f0 = fills;
    rd(mk(5, 3) + 32'd3, d, w);
    chk("R10 offset hit", 32'(w), 0);
    chk("R10 offset data", d, mval(mk(5, 3)));
    for (int i = 0; i < LINES; i++) begin
      rd(mk(9, i), d, w);
      chk("R10 conflict miss", 32'(w > 0), 1);
      chk("R10 conflict data", d, mval(mk(9, i)));
    end
    chk("R10 fill count", 32'(fills - f0), 32'(LINES));
    rd(mk(5, 0), d, w);
    chk("R10 evicted refetch", 32'(w > 0), 1);

    // R4 R5: full-word writes with drain held
    wb_ready = 1'b0;
    f0 = fills;
    for (int i = 0; i < WB_DEPTH; i++) begin
      wr(mk(12, i), 32'hC0DE_0000 + 32'(i) * 32'h1111, 4'hF, w);
      chk("R4 write no stall", 32'(w), 0);
    end
    for (int i = 0; i < WB_DEPTH; i++) begin
      rd(mk(12, i), d, w);
      chk("R4 write hit", 32'(w), 0);
      chk("R4 write data", d, 32'hC0DE_0000 + 32'(i) * 32'h1111);
    end
    chk("R4 no fill", 32'(fills - f0), 0);
    rd(mk(9, 3), d, w);
    chk("R4 write evicted old tag", 32'(w > 0), 1);
    chk("R5 nothing drained yet", 32'(n_pop), 0);

    // R6: fifth write stalls while full
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = mk(12, 4); cpu_wdata = 32'hFEED_0004; cpu_be = 4'hF;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R6 full stall", 32'(cpu_stall), 1);
      chk("R6 head unchanged", wb_addr, mk(12, 0));
      @(negedge clk);
    end
    exp_a[n_push] = mk(12, 4); exp_d[n_push] = 32'hFEED_0004; exp_be[n_push] = 4'hF; n_push++;
    wb_ready = 1'b1;
    #1; w = 0;
    while (cpu_stall && w < 200) begin @(negedge clk); #1; w++; end
    chk("R6 released after drain", 32'(cpu_stall), 0);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 R6 drained count", 32'(n_pop), 32'(WB_DEPTH + 1));

    // R7: partial write invalidates
    f0 = fills;
    wr(mk(12, 1), 32'h0BAD_BEEF, 4'b0011, w);
    chk("R7 partial no stall", 32'(w), 0);
    rd(mk(12, 1), d, w);
    chk("R7 partial then miss", 32'(w > 0), 1);
    chk("R7 refill data", d, mval(mk(12, 1)));
    chk("R7 one fill", 32'(fills - f0), 1);
    repeat (4) @(negedge clk);
    chk("R7 partial drained", 32'(n_pop), 32'(n_push));

    // R8: miss waits for matching buffered writes
    wb_ready = 1'b0;
    wr(mk(20, 5), 32'h1111_2222, 4'hF, w);
    wr(mk(20, 5) + 32'd2, 32'h3333_4444, 4'b1100, w);
    f0 = fills;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(20, 5);
    for (int k = 0; k < 6; k++) begin
      #1;
      chk("R8 stalled", 32'(cpu_stall), 1);
      chk("R8 no fetch while match", 32'(mem_rd_req), 0);
      @(negedge clk);
    end
    wb_ready = 1'b1;
    seen_pop = -1;
    #1; w = 0;
    while (cpu_stall && w < 200) begin
      if (mem_rd_req && seen_pop < 0) seen_pop = n_pop;
      @(negedge clk); #1; w++;
    end
    chk("R8 drained before fetch", 32'(seen_pop), 32'(n_push));
    chk("R8 data", cpu_rdata, mval(mk(20, 5)));
    chk("R8 one fill", 32'(fills - f0), 1);
    @(negedge clk);
    cpu_req = 1'b0;

    // R9: cancelled accesses
    repeat (4) @(negedge clk);
    wb_ready = 1'b0;
    f0 = fills;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_be = 4'hF; cpu_addr = mk(12, 0);
    cpu_wdata = 32'hDEAD_0000; xlat_ok = 1'b0;
    for (int k = 0; k < 2; k++) begin
      #1;
      chk("R9 cancelled write no stall", 32'(cpu_stall), 0);
      @(negedge clk);
    end
    cpu_req = 1'b0; cpu_we = 1'b0; xlat_ok = 1'b1;
    #1;
    chk("R9 no buffer entry", 32'(wb_valid), 0);
    rd(mk(12, 0), d, w);
    chk("R9 line unchanged hit", 32'(w), 0);
    chk("R9 line unchanged data", d, 32'hC0DE_0000);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = mk(30, 6); xlat_ok = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R9 cancelled read no stall", 32'(cpu_stall), 0);
      chk("R9 cancelled read no fetch", 32'(mem_rd_req), 0);
      @(negedge clk);
    end
    cpu_req = 1'b0; xlat_ok = 1'b1;
    chk("R9 no fill", 32'(fills - f0), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule